// File: doc/BRIEF.md
# Biphase-mark subframe receiver

This block takes one already-digitized, asynchronous line carrying biphase-mark coded digital audio. It samples the line with a fast local clock and returns each 32-bit subframe as a parallel word. The line first passes through a synchronizer. Every change of level, rising or falling, then becomes a single one-cycle event, so the absolute polarity of the line never matters.

The spacing between events is counted in local clock cycles. The shortest spacing seen over a sliding window of events is taken as the half-bit length. Each spacing is then sorted into one, two or three half-bits by thresholds at 1.5, 2.5 and 3.5 times that estimate. No rate constant is preset, so the same build follows 32, 44.1 or 48 kHz streams, provided the local clock is at least eight times the half-bit rate.

A gap of three half-bits can only occur in a preamble. It marks the start of a subframe. The spacing that follows the gap tells which preamble it was. The 28 data cells that come after are decoded and shifted into the word from the top. When the 28th cell closes, the word is presented with a one-cycle strobe and the preamble code, and the lock flag is raised.

Top module: `bmc_subframe_rx`

## Requirements
- R1: While reset is held, and after it is released with no line activity, `locked_o` and `word_valid_o` are 0, and `word_o` and `pre_type_o` are all zeros.
- R2: Only level changes carry information. The same coded sequence starting from a low line or from a high line yields identical words and preamble codes.
- R3: The first data cell after the preamble lands in `word_o[4]`, and the 28th lands in `word_o[31]`. The four preamble slots `word_o[3:0]` always read 0.
- R4: A data cell whose only transition is at its start decodes as 0. A cell with an extra transition at mid-cell decodes as 1.
- R5: `pre_type_o` codes the preamble that opened the word from the spacings after the three-half-bit gap: 2'b01 for block start (3,1,1,3 half-bits), 2'b10 for channel A (3,3,1,1), 2'b11 for channel B (3,2,1,2). Code 2'b00 never comes with a valid word.
- R6: Each completed subframe gives exactly one one-cycle `word_valid_o` pulse. `locked_o` rises together with that pulse and stays high while subframes keep arriving intact. `word_o` changes only together with the strobe.
- R7: Half-bit lengths of 12, 16 and 24 clock cycles all decode correctly, with no reset or setting between rate changes. Each change needs only a few warm-up subframes.
- R8: Jitter of plus or minus one clock cycle on every transition spacing, at a half-bit of 12 cycles, does not change any decoded word.
- R9: If the line is idle for more than four estimated half-bits, `locked_o` drops to 0 and the unfinished subframe gives no word.
- R10: A spacing that is illegal where it occurs, such as a three-half-bit gap inside the data field, drops `locked_o` and discards that subframe. The next intact subframes are decoded and locked again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least eight times the half-bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Digitized coded line, asynchronous to clk |
| word_o | output | SUB_BITS (32) | Last completed subframe, first cell received at the lowest data position |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| pre_type_o | output | 2 | Preamble code of the word on `word_o` |
| locked_o | output | 1 | Subframe framing currently held |

## Verification
The assertions assume a line whose transitions are at least two sampling cycles apart. They also assume subframes far longer than one cycle, so that strobes can never come back to back. The stimulus toggles the line only on falling clock edges and holds every level for at least eleven cycles, even under jitter. Rate switches and corrupted subframes are only ever preceded by warm-up traffic that cannot pass for a complete subframe. Every strobe the bench records therefore belongs to a subframe whose contents it knows.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  // spacing classes in units of the estimated half-bit
  typedef enum logic [1:0] {
    IV_ONE   = 2'd0,
    IV_TWO   = 2'd1,
    IV_THREE = 2'd2,
    IV_BAD   = 2'd3
  } iv_cls_t;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_NEXT = 2'd3
  } frm_st_t;

  localparam logic [1:0] PT_NONE  = 2'b00;
  localparam logic [1:0] PT_BLOCK = 2'b01;
  localparam logic [1:0] PT_CHA   = 2'b10;
  localparam logic [1:0] PT_CHB   = 2'b11;

  function automatic logic [1:0] cls_halves(input iv_cls_t c);
    case (c)
      IV_ONE:   return 2'd1;
      IV_TWO:   return 2'd2;
      IV_THREE: return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bmc_edge_det.sv
module bmc_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic edge_o
);

  localparam int SW = SYNC_STAGES + 1;

  logic [SW-1:0] sh_r;
  logic [SW-1:0] sh_n;

  always_comb begin
    sh_n = {sh_r[SW-2:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_r <= '0;
    end else begin
      sh_r <= sh_n;
    end
  end

  // one-cycle pulse on any level change of the synchronized line
  assign edge_o = sh_r[SW-1] ^ sh_r[SW-2];

endmodule

// File: rtl/bmc_interval_meter.sv
module bmc_interval_meter
  import bmc_pkg::*;
#(
  parameter int CW  = 10,
  parameter int WIN = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    edge_i,
  output logic    iv_vld_o,
  output iv_cls_t iv_cls_o,
  output logic    tmo_o,
  output logic    est_ok_o
);

  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int XW = CW + 3;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN - 1);

  logic [CW-1:0] cnt_r, cnt_n;
  logic          seen_r, seen_n;
  logic [WW-1:0] win_r, win_n;
  logic [CW-1:0] wmin_r, wmin_n;
  logic [CW-1:0] est_r, est_n;
  logic          ok_r, ok_n;
  logic          vld_r, vld_n;
  iv_cls_t       cls_r, cls_n;
  logic          tmo_r, tmo_n;

  logic [XW-1:0] len2, ex, e3, e4, e5, e7;
  logic          meas_en;

  always_comb begin
    // thresholds scaled by two so that 1.5, 2.5 and 3.5 stay integral
    len2 = {2'b00, cnt_r, 1'b0};
    ex   = {3'b000, est_r};
    e3   = ex + {ex[XW-2:0], 1'b0};
    e4   = {ex[XW-3:0], 2'b00};
    e5   = e4 + ex;
    e7   = e4 + e3;

    cnt_n = cnt_r;
    if (edge_i) begin
      cnt_n = CW'(1);
    end else if (cnt_r != '1) begin
      cnt_n = cnt_r + CW'(1);
    end

    seen_n  = seen_r | edge_i;
    meas_en = edge_i & seen_r;

    if (len2 < e3) begin
      cls_n = IV_ONE;
    end else if (len2 < e5) begin
      cls_n = IV_TWO;
    end else if (len2 < e7) begin
      cls_n = IV_THREE;
    end else begin
      cls_n = IV_BAD;
    end
    if (!meas_en) begin
      cls_n = cls_r;
    end
    vld_n = meas_en & ok_r;

    win_n  = win_r;
    wmin_n = wmin_r;
    est_n  = est_r;
    ok_n   = ok_r;
    if (meas_en) begin
      wmin_n = ((win_r == '0) || (cnt_r < wmin_r)) ? cnt_r : wmin_r;
      if (win_r == WIN_LAST) begin
        win_n = '0;
        est_n = wmin_n;
        ok_n  = 1'b1;
      end else begin
        win_n = win_r + WW'(1);
      end
    end

    tmo_n = ok_r & ~edge_i & ({3'b000, cnt_r} >= e4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      seen_r <= 1'b0;
      win_r  <= '0;
      wmin_r <= '0;
      est_r  <= '0;
      ok_r   <= 1'b0;
      vld_r  <= 1'b0;
      cls_r  <= IV_BAD;
      tmo_r  <= 1'b0;
    end else begin
      cnt_r  <= cnt_n;
      seen_r <= seen_n;
      win_r  <= win_n;
      wmin_r <= wmin_n;
      est_r  <= est_n;
      ok_r   <= ok_n;
      vld_r  <= vld_n;
      cls_r  <= cls_n;
      tmo_r  <= tmo_n;
    end
  end

  assign iv_vld_o = vld_r;
  assign iv_cls_o = cls_r;
  assign tmo_o    = tmo_r;
  assign est_ok_o = ok_r;

endmodule

// File: rtl/bmc_framer.sv
module bmc_framer
  import bmc_pkg::*;
#(
  parameter int SUB_BITS  = 32,
  parameter int PRE_SLOTS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iv_vld_i,
  input  iv_cls_t             iv_cls_i,
  input  logic                tmo_i,
  input  logic                est_ok_i,
  output logic [SUB_BITS-1:0] word_o,
  output logic                word_valid_o,
  output logic [1:0]          pre_type_o,
  output logic                locked_o
);

  localparam int DATA_BITS  = SUB_BITS - PRE_SLOTS;
  localparam int PRE_HALVES = 2 * PRE_SLOTS;
  localparam int BCW        = $clog2(DATA_BITS);
  localparam int HW         = $clog2(PRE_HALVES + 4);
  localparam logic [BCW-1:0] BC_LAST = BCW'(DATA_BITS - 1);
  localparam logic [HW-1:0]  HV_END  = HW'(PRE_HALVES);

  frm_st_t             st_r, st_n;
  logic [HW-1:0]       hv_r, hv_n, hv_sum;
  logic [BCW-1:0]      bc_r, bc_n;
  logic                pend_r, pend_n;
  logic [SUB_BITS-1:0] sh_r, sh_n;
  logic [1:0]          pt_r, pt_n;
  logic [SUB_BITS-1:0] word_r, word_n;
  logic [1:0]          ptype_r, ptype_n;
  logic                val_r, val_n;
  logic                lock_r, lock_n;
  logic                bit_en, bit_v, err;

  always_comb begin
    st_n    = st_r;
    hv_n    = hv_r;
    bc_n    = bc_r;
    pend_n  = pend_r;
    sh_n    = sh_r;
    pt_n    = pt_r;
    word_n  = word_r;
    ptype_n = ptype_r;
    val_n   = 1'b0;
    lock_n  = lock_r;
    bit_en  = 1'b0;
    bit_v   = 1'b0;
    err     = 1'b0;
    hv_sum  = hv_r + HW'(cls_halves(iv_cls_i));

    if (tmo_i || !est_ok_i) begin
      err = 1'b1;
    end else if (iv_vld_i) begin
      if (iv_cls_i == IV_BAD) begin
        err = 1'b1;
      end else begin
        case (st_r)
          ST_HUNT, ST_NEXT: begin
            if (iv_cls_i == IV_THREE) begin
              st_n = ST_PRE;
              hv_n = HW'(3);
              sh_n = '0;
            end else if (st_r == ST_NEXT) begin
              err = 1'b1;
            end
          end
          ST_PRE: begin
            if (hv_r == HW'(3)) begin
              case (iv_cls_i)
                IV_ONE:  pt_n = PT_BLOCK;
                IV_TWO:  pt_n = PT_CHB;
                default: pt_n = PT_CHA;
              endcase
            end
            if (hv_sum == HV_END) begin
              st_n   = ST_DATA;
              bc_n   = '0;
              pend_n = 1'b0;
            end else if (hv_sum > HV_END) begin
              err = 1'b1;
            end else begin
              hv_n = hv_sum;
            end
          end
          ST_DATA: begin
            case (iv_cls_i)
              IV_TWO: begin
                if (pend_r) begin
                  err = 1'b1;
                end else begin
                  bit_en = 1'b1;
                end
              end
              IV_ONE: begin
                if (pend_r) begin
                  pend_n = 1'b0;
                  bit_en = 1'b1;
                  bit_v  = 1'b1;
                end else begin
                  pend_n = 1'b1;
                end
              end
              default: err = 1'b1;
            endcase
          end
          default: err = 1'b1;
        endcase
      end
    end

    if (bit_en) begin
      // new cells enter at the top, the first one drifts down to the lowest data slot
      sh_n = {bit_v, sh_r[SUB_BITS-1:1]};
      if (bc_r == BC_LAST) begin
        word_n  = sh_n;
        ptype_n = pt_r;
        val_n   = 1'b1;
        lock_n  = 1'b1;
        st_n    = ST_NEXT;
      end else begin
        bc_n = bc_r + BCW'(1);
      end
    end

    if (err) begin
      st_n   = ST_HUNT;
      lock_n = 1'b0;
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r    <= ST_HUNT;
      hv_r    <= '0;
      bc_r    <= '0;
      pend_r  <= 1'b0;
      sh_r    <= '0;
      pt_r    <= PT_NONE;
      word_r  <= '0;
      ptype_r <= PT_NONE;
      val_r   <= 1'b0;
      lock_r  <= 1'b0;
    end else begin
      st_r    <= st_n;
      hv_r    <= hv_n;
      bc_r    <= bc_n;
      pend_r  <= pend_n;
      sh_r    <= sh_n;
      pt_r    <= pt_n;
      word_r  <= word_n;
      ptype_r <= ptype_n;
      val_r   <= val_n;
      lock_r  <= lock_n;
    end
  end

  assign word_o       = word_r;
  assign word_valid_o = val_r;
  assign pre_type_o   = ptype_r;
  assign locked_o     = lock_r;

endmodule

// File: rtl/bmc_subframe_rx.sv
module bmc_subframe_rx
  import bmc_pkg::*;
#(
  parameter int SUB_BITS    = 32,
  parameter int PRE_SLOTS   = 4,
  parameter int CW          = 10,
  parameter int WIN         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_i,
  output logic [SUB_BITS-1:0] word_o,
  output logic                word_valid_o,
  output logic [1:0]          pre_type_o,
  output logic                locked_o
);

  logic [1:0] rs_r;
  logic       rst_q_n;
  logic       edge_w;
  logic       iv_vld_w;
  iv_cls_t    iv_cls_w;
  logic       tmo_w;
  logic       est_ok_w;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_r <= '0;
    end else begin
      rs_r <= {rs_r[0], 1'b1};
    end
  end
  assign rst_q_n = rs_r[1];

  bmc_edge_det #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .line_i (line_i),
    .edge_o (edge_w)
  );

  bmc_interval_meter #(
    .CW  (CW),
    .WIN (WIN)
  ) u_meter (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .edge_i   (edge_w),
    .iv_vld_o (iv_vld_w),
    .iv_cls_o (iv_cls_w),
    .tmo_o    (tmo_w),
    .est_ok_o (est_ok_w)
  );

  bmc_framer #(
    .SUB_BITS  (SUB_BITS),
    .PRE_SLOTS (PRE_SLOTS)
  ) u_framer (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .iv_vld_i     (iv_vld_w),
    .iv_cls_i     (iv_cls_w),
    .tmo_i        (tmo_w),
    .est_ok_i     (est_ok_w),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .pre_type_o   (pre_type_o),
    .locked_o     (locked_o)
  );

endmodule

// File: rtl/bmc_subframe_rx_chk.sv
module bmc_subframe_rx_chk #(
  parameter int SUB_BITS  = 32,
  parameter int PRE_SLOTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SUB_BITS-1:0] word_o,
  input logic                word_valid_o,
  input logic [1:0]          pre_type_o,
  input logic                locked_o,
  input logic                edge_i,
  input logic                iv_vld_i
);

  // R6
  strobe_with_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> locked_o);

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> word_valid_o);

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> $stable(word_o));

  // R5
  type_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (pre_type_o != 2'b00));

  // R3
  pre_slots_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (word_o[PRE_SLOTS-1:0] == '0));

  // R2
  interval_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iv_vld_i |-> $past(edge_i));

endmodule

bind bmc_subframe_rx bmc_subframe_rx_chk #(
  .SUB_BITS  (SUB_BITS),
  .PRE_SLOTS (PRE_SLOTS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .word_o       (word_o),
  .word_valid_o (word_valid_o),
  .pre_type_o   (pre_type_o),
  .locked_o     (locked_o),
  .edge_i       (edge_w),
  .iv_vld_i     (iv_vld_w)
);

// File: tb/bmc_subframe_rx_test.sv
`timescale 1ns/1ps
module bmc_subframe_rx_test;

  localparam logic [1:0] T_BLK = 2'b01;
  localparam logic [1:0] T_A   = 2'b10;
  localparam logic [1:0] T_B   = 2'b11;

  logic        clk;
  logic        rst_n;
  logic        line_i;
  logic [31:0] word_o;
  logic        word_valid_o;
  logic [1:0]  pre_type_o;
  logic        locked_o;

  bmc_subframe_rx uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line_i),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .pre_type_o   (pre_type_o),
    .locked_o     (locked_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          vectors = 0;
  int          fails   = 0;
  bit          done    = 1'b0;
  int          hb      = 16;
  bit          jit_on  = 1'b0;
  bit          clr_pend = 1'b0;
  logic        ln      = 1'b0;
  logic [15:0] lfsr    = 16'hACE1;

  logic [31:0] exp_w [64];
  logic [1:0]  exp_t [64];
  int          exp_n = 0;
  logic [31:0] rx_w  [64];
  logic [1:0]  rx_t  [64];
  int          rx_n  = 0;
  logic        prev_v = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, expv);
    end
  endtask

  // capture every strobe; a strobe on two samples in a row breaks R6
  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid_o) begin
        if (rx_n < 64) begin
          rx_w[rx_n] = word_o;
          rx_t[rx_n] = pre_type_o;
          rx_n++;
        end
        if (prev_v) chk(1'b0, "R6 strobe width", 32'd2, 32'd1);
      end
      prev_v = word_valid_o;
    end
  end

  task automatic emit(input int n);
    int len;
    ln     = ~ln;
    line_i = ln;
    len    = n * hb;
    if (jit_on) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      len  = len + int'(lfsr % 16'd3) - 1;
    end
    if (clr_pend) begin
      repeat (8) @(negedge clk);
      rx_n     = 0;
      clr_pend = 1'b0;
      len      = len - 8;
    end
    repeat (len) @(negedge clk);
  endtask

  task automatic send_sub(input logic [1:0] t, input logic [27:0] d, input int bad_at, input bit rec);
    case (t)
      T_BLK:   begin emit(3); emit(1); emit(1); emit(3); end
      T_A:     begin emit(3); emit(3); emit(1); emit(1); end
      default: begin emit(3); emit(2); emit(1); emit(2); end
    endcase
    for (int k = 0; k < 28; k++) begin
      if (k == bad_at) emit(3);
      else if (d[k]) begin emit(1); emit(1); end
      else emit(2);
    end
    if (rec) begin
      exp_w[exp_n] = {d, 4'b0000};
      exp_t[exp_n] = t;
      exp_n++;
    end
  endtask

  task automatic warm(input int n);
    for (int i = 0; i < n; i++) send_sub((i % 2 == 0) ? T_A : T_B, 28'hFFFFFFF ^ 28'(i * 28'h1111111), -1, 1'b0);
    clr_pend = 1'b1;
    exp_n    = 0;
  endtask

  task automatic finish_phase(input string rq);
    send_sub(T_A, 28'h0F0F0F0, -1, 1'b0);
    repeat (4) @(negedge clk);
    chk(locked_o == 1'b1, "R6 lock held", 32'(locked_o), 32'd1);
    repeat (5 * hb + 12) @(negedge clk);
    chk(locked_o == 1'b0, "R9 idle drops lock", 32'(locked_o), 32'd0);
    chk(rx_n == exp_n, {rq, " word count (R9 no partial word)"}, 32'(rx_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < rx_n; i++) begin
      chk(rx_w[i] == exp_w[i], {rq, " R3 R4 word"}, rx_w[i], exp_w[i]);
      chk(rx_t[i] == exp_t[i], {rq, " R5 preamble code"}, 32'(rx_t[i]), 32'(exp_t[i]));
    end
  endtask

  task automatic do_reset(input logic lvl);
    rst_n  = 1'b0;
    ln     = lvl;
    line_i = lvl;
    repeat (5) @(negedge clk);
    chk(locked_o == 1'b0 && word_valid_o == 1'b0, "R1 flags in reset", {30'd0, locked_o, word_valid_o}, 32'd0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(word_o == 32'd0, "R1 word after reset", word_o, 32'd0);
    chk(pre_type_o == 2'b00, "R1 code after reset", 32'(pre_type_o), 32'd0);
    chk(locked_o == 1'b0, "R1 lock after reset", 32'(locked_o), 32'd0);
  endtask

  task automatic base_set;
    send_sub(T_BLK, 28'h0000000, -1, 1'b1);
    send_sub(T_A,   28'hFFFFFFF, -1, 1'b1);
    send_sub(T_B,   28'h5555555, -1, 1'b1);
    send_sub(T_A,   28'hAAAAAAA, -1, 1'b1);
    send_sub(T_B,   28'h1234567, -1, 1'b1);
    send_sub(T_BLK, 28'hC0FFEE1, -1, 1'b1);
  endtask

  initial begin
    rst_n  = 1'b0;
    line_i = 1'b0;
    @(negedge clk);

    // base rate, line starting low
    hb = 16;
    do_reset(1'b0);
    warm(4);
    base_set();
    finish_phase("R4 base");

    // same traffic from the opposite starting level
    do_reset(1'b1);
    warm(4);
    base_set();
    finish_phase("R2 inverted");

    // slower rate, no reset
    hb = 24;
    warm(4);
    send_sub(T_BLK, 28'h8000001, -1, 1'b1);
    send_sub(T_A,   28'h7FFFFFE, -1, 1'b1);
    send_sub(T_B,   28'h0000001, -1, 1'b1);
    send_sub(T_A,   28'h8000000, -1, 1'b1);
    finish_phase("R7 slow");

    // faster rate with jitter, walking one over every data cell
    hb     = 12;
    jit_on = 1'b1;
    warm(4);
    for (int k = 0; k < 28; k++)
      send_sub((k == 0) ? T_BLK : ((k % 2 == 1) ? T_A : T_B), 28'd1 << k, -1, 1'b1);
    finish_phase("R8 jitter walk");
    jit_on = 1'b0;

    // corrupted subframe in the middle
    hb = 16;
    warm(4);
    send_sub(T_A, 28'h2468ACE, -1, 1'b1);
    send_sub(T_B, 28'h3FFFFFF, 10, 1'b0);
    chk(locked_o == 1'b0, "R10 lock after illegal gap", 32'(locked_o), 32'd0);
    send_sub(T_BLK, 28'h0ABCDEF, -1, 1'b1);
    send_sub(T_A,   28'h1357913, -1, 1'b1);
    finish_phase("R10 recovery");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule